// File: doc/BRIEF.md
# Lock-Qualified Power-On Reset Generator

This block produces the internal reset for an FPGA design that has neither a reset pin nor an external supervisor device. Every register inside it takes its starting value from its declared initial value when the device is configured, so the reset output is high from the first instant without any clearing input. A counter then measures how long the clock has been stable. It advances once per rising edge, but only while the clock generator reports lock. When the count reaches a terminal value, the reset is released. If lock is lost, the count starts over.

The lock indication passes through a chain of synchronising flops before it is used. A small sequencer with three states then drives the reset register:

- `ST_UNLOCKED`: count cleared, reset high.
- `ST_COUNTING`: count advancing, reset high.
- `ST_RELEASED`: count held at the terminal value, reset low.

The transitions are:

- `ST_UNLOCKED` to `ST_COUNTING` on the first synchronised lock.
- `ST_COUNTING` to `ST_RELEASED` when the count reaches the terminal value.
- Any state back to `ST_UNLOCKED` whenever the synchronised lock is low.

Top module: `por_gen`

## Requirements
- R1: `rst_out` is 1 from configuration (time zero), before any clock edge, with no reset input involved.
- R2: `lock_in` passes through two flop stages before it is used. A value applied to `lock_in` before rising edge n first affects counting at edge n+2.
- R3: While the synchronised lock is 1, the internal count rises by exactly one per rising edge until it equals `TERM_COUNT` (default 16, minimum 2). It then holds at that value.
- R4: `rst_out` goes to 0 on the edge where the count reaches `TERM_COUNT`. If `lock_in` is first sampled 1 at edge e and then stays 1, `rst_out` is 0 from edge e+1+`TERM_COUNT` onward.
- R5: Any edge that sees the synchronised lock at 0 clears the count and drives `rst_out` to 1. After lock returns, the full `TERM_COUNT` run is required again before release.
- R6: A drop of lock during counting, even for one cycle, restarts the count from zero; no partial progress is kept.
- R7: `rst_out` comes straight from a flop and changes only at rising edges of `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock from the clock generator |
| lock_in | input | 1 | Lock status of the clock generator, asynchronous, 1 = locked |
| rst_out | output | 1 | Synchronous active-high reset for downstream logic |

## Verification
The assertions assume that the initial values of the registers actually load at configuration. They also assume that `lock_in`, although asynchronous, settles well away from the sampling edge, so that the synchroniser stages carry clean 0/1 values. The bench changes `lock_in` only on falling edges. Its random segments mix long lock periods with single-cycle drops and recoveries. A second-order metastability model is therefore never needed to predict the reset.

// File: rtl/por_pkg.sv
package por_pkg;
    typedef enum logic [1:0] {
        ST_UNLOCKED = 2'd0,
        ST_COUNTING = 2'd1,
        ST_RELEASED = 2'd2
    } por_state_t;
endpackage

// File: rtl/por_lock_sync.sv
module por_lock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic async_in,
    output logic sync_out
);
    // Chain loads zero at configuration: the clock is treated as unlocked.
    logic [STAGES-1:0] chain = '0;

    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/por_release_fsm.sv
module por_release_fsm
    import por_pkg::*;
#(
    parameter int TERM = 16
) (
    input  logic clk,
    input  logic lock_ok,
    output logic rst_o
);
    localparam int CW = $clog2(TERM + 1);
    localparam logic [CW-1:0] TERM_C = CW'(TERM);
    localparam logic [CW-1:0] ONE_C  = CW'(1);

    por_state_t    state   = ST_UNLOCKED;
    por_state_t    state_n;
    logic [CW-1:0] cnt     = '0;
    logic [CW-1:0] cnt_n;
    logic          rst_q   = 1'b1;

    // Next-state and next-count logic.
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        if (!lock_ok) begin
            state_n = ST_UNLOCKED;
            cnt_n   = '0;
        end else begin
            unique case (state)
                ST_UNLOCKED: begin
                    cnt_n   = ONE_C;
                    state_n = ST_COUNTING;
                end
                ST_COUNTING: begin
                    cnt_n = cnt + ONE_C;
                    if (cnt_n == TERM_C) state_n = ST_RELEASED;
                end
                ST_RELEASED: begin
                    cnt_n   = cnt;
                    state_n = ST_RELEASED;
                end
                default: begin
                    cnt_n   = '0;
                    state_n = ST_UNLOCKED;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        state <= state_n;
        cnt   <= cnt_n;
    end

    // Output register.
    always_ff @(posedge clk) begin
        rst_q <= (state_n != ST_RELEASED);
    end

    assign rst_o = rst_q;

    // Enables the properties only after the first edge.
    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    p_unlock_asserts_r5: assert property (@(posedge clk) disable iff (!armed)
        !lock_ok |=> (rst_q && cnt == '0));

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!armed)
        cnt <= TERM_C);

    p_step_r3: assert property (@(posedge clk) disable iff (!armed)
        (lock_ok && state != ST_RELEASED) |=> cnt == CW'($past(cnt) + ONE_C));

    p_hold_r3: assert property (@(posedge clk) disable iff (!armed)
        (lock_ok && state == ST_RELEASED) |=> ($stable(cnt) && !rst_q));

    p_release_r4: assert property (@(posedge clk) disable iff (!armed)
        $fell(rst_q) |-> (cnt == TERM_C));

    p_restart_r6: assert property (@(posedge clk) disable iff (!armed)
        $rose(rst_q) |-> (cnt == '0));
endmodule

// File: rtl/por_gen.sv
module por_gen #(
    parameter int TERM_COUNT  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic lock_in,
    output logic rst_out
);
    logic lock_sync;

    por_lock_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .async_in(lock_in),
        .sync_out(lock_sync)
    );

    por_release_fsm #(
        .TERM(TERM_COUNT)
    ) u_fsm (
        .clk    (clk),
        .lock_ok(lock_sync),
        .rst_o  (rst_out)
    );

    // R1: high before any edge.
    initial begin
        #0 a_cfg_high_r1: assert (rst_out === 1'b1);
    end
endmodule

// File: tb/test_por_gen.sv
module test_por_gen;
    localparam int TERM = 16;

    logic clk = 1'b0;
    logic lock_in = 1'b0;
    logic rst_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    por_gen #(.TERM_COUNT(TERM), .SYNC_STAGES(2)) i_por_gen (
        .clk    (clk),
        .lock_in(lock_in),
        .rst_out(rst_out)
    );

    // Port-level model built from the requirements.
    logic m_s1 = 1'b0, m_s2 = 1'b0;
    int   m_cnt = 0;
    logic m_rst = 1'b1;

    function automatic int next_cnt(int c, logic lk);
        if (!lk) return 0;
        return (c < TERM) ? c + 1 : c;
    endfunction

    always @(posedge clk) begin
        int c;
        c = next_cnt(m_cnt, m_s2);
        m_s1  <= lock_in;
        m_s2  <= m_s1;
        m_cnt <= c;
        m_rst <= (c != TERM);
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rst_out=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive a level for n cycles, checking the model on every falling edge.
    task automatic run(input logic lk, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(req, rst_out, m_rst);
            lock_in = lk;
        end
    endtask

    // Applies lock at a falling edge, counts edges until release.
    task automatic measure_release(input string req);
        int edges = 0;
        @(negedge clk);
        lock_in = 1'b1;
        while (rst_out === 1'b1 && edges < 3 * TERM) begin
            @(negedge clk);
            edges++;
        end
        n_tests++;
        if (edges != TERM + 2) begin
            n_fail++;
            $display("FAIL %s: release after %0d edges expected %0d", req, edges, TERM + 2);
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        #1;
        check("R1", rst_out, 1'b1);

        // R1/R2: unlocked after configuration keeps reset high.
        run(1'b0, 8, "R1");
        // R2/R4: exact release latency after lock.
        measure_release("R4");
        run(1'b1, 10, "R3");
        check("R3", rst_out, 1'b0);

        // R5: loss of lock after release, then full rerun.
        @(negedge clk); lock_in = 1'b0;
        @(negedge clk); check("R2", rst_out, 1'b0);
        @(negedge clk); check("R2", rst_out, 1'b0);
        @(negedge clk); check("R5", rst_out, 1'b1);
        run(1'b0, 3, "R5");
        measure_release("R5");

        // R6: single-cycle drop midway through the count.
        run(1'b0, 4, "R6");
        run(1'b1, TERM / 2 + 2, "R6");
        run(1'b0, 1, "R6");
        run(1'b1, TERM + 1, "R6");
        check("R6", rst_out, 1'b1);
        run(1'b1, 2, "R6");
        check("R6", rst_out, 1'b0);

        // Constrained random segments.
        for (int s = 0; s < 80; s++) begin
            logic lk;
            int len;
            lk  = ($urandom_range(0, 3) != 0);
            len = lk ? $urandom_range(1, 2 * TERM + 4) : $urandom_range(1, 6);
            run(lk, len, "R3");
        end

        // R7: output stable across a whole high phase.
        @(posedge clk); #2;
        begin
            logic v;
            v = rst_out;
            #6;
            check("R7", rst_out, v);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: timeout actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule